// File: doc/BRIEF.md
# Chained Serial Control Port Decoder

This block is the serial slave front end of one channel in a chain of devices that share a single chip select and serial clock. Each frame starts with a control byte. An address byte follows, and then a data field. Every field is sent MSB first. The control byte holds three flags, a spare bit and a channel number. The channel number is stored in reversed bit order so that its least significant bit arrives first. That order lets each channel subtract one from the number serially, in the same pass that forwards the stream to the next channel on a pass-through output. A channel acts on the frame only when the number it receives is zero, or when the frame is a broadcast write.

Towards the core, the block drives a simple register-file port. The port issues one-cycle read and write strobes, a space select (8-bit registers or 16-bit memory words), an address and write data. Read data returns one clock after the read strobe. Register reads return the value addressed in the current frame. Memory reads are pipelined one deep: a frame returns the word that the previous memory read fetched, and it starts the fetch for its own address.

The serial inputs are sampled by the block clock through synchronisers. Each serial-clock phase must therefore last at least four block clocks.

Top module: `daisy_spi_decoder`

## Requirements
- R1: The control byte is received MSB first. Bit 7 is the broadcast flag, bit 6 is the direction (1 = read), bit 5 is the space (1 = memory, 0 = register) and bit 4 is spare and ignored. Bits 3..0 hold the channel number reversed: bit 3 is its LSB and bit 0 is its MSB.
- R2: When broadcast is clear, a channel acts on the frame only if the received channel number is zero. A write frame with a nonzero number produces no write strobe.
- R3: A write with the broadcast flag set acts on the frame whatever the channel number. A read with the broadcast flag set and a nonzero channel number produces no read strobe and leaves the serial output disabled.
- R4: The pass-through output repeats every received bit one serial clock later, launched on the falling edge. In the control byte, the channel number is decremented by one modulo 16 in its reversed order, and bits 7..4 are unchanged. The output is 0 while chip select is high.
- R5: A register read returns `rf_rdata[7:0]` of the address sent in the same frame. It is shifted out MSB first on the 8 serial-clock falling edges after the address byte, which make up bits 16..23 of the frame.
- R6: A memory read shifts out 16 bits MSB first, which are the word fetched by the previous memory read frame. After reset, that word is 0. The frame also strobes a read of its own address, and the result is kept for the next memory read.
- R7: A register write frame has 24 bits and a memory write frame has 32 bits. Each produces exactly one `rf_wr` pulse, carrying the address and the data (8 or 16 bits), after the last data bit is sampled. Read and write strobes are never high in the same cycle.
- R8: `spi_sdo_oe` is 1 only from the data phase of a read frame aimed at this channel until chip select rises. At all other times it is 0.
- R9: When chip select rises before the last data bit of a write, no write occurs. When it rises before the address byte of a memory read is complete, the memory read pipeline is not affected.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low, data sampled on rising edge |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial read data out |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo (0 = high impedance) |
| spi_thru | output | 1 | Pass-through stream to the next channel |
| rf_rd | output | 1 | Register-file read strobe |
| rf_wr | output | 1 | Register-file write strobe |
| rf_ram | output | 1 | Space select for the strobe (1 = memory) |
| rf_addr | output | 8 | Register-file address |
| rf_wdata | output | 16 | Write data (register writes use the low 8 bits) |
| rf_rdata | input | 16 | Read data, valid one clock after rf_rd |

## Verification
The hardest situation to reach is the memory read pipeline meeting an aborted frame. This is a read whose address phase is cut short, placed between two complete memory reads with a memory write in the middle. Only the data returned by the following read shows whether the one-deep buffer was disturbed. The bench builds this sequence on purpose and predicts each returned word from its own record of the previous read address. It also sweeps all sixteen channel numbers, with broadcast clear and with broadcast set. On each frame it reassembles the control byte from the pass-through output and compares it with the decrement computed in the reversed order.

// File: rtl/daisy_spi_pkg.sv
package daisy_spi_pkg;
  // Control byte flag offsets counted down from its MSB
  localparam int OFS_BCAST = 0;
  localparam int OFS_RDIR  = 1;
  localparam int OFS_SPACE = 2;
  localparam int N_FLAGS   = 4;

  typedef enum logic [1:0] {
    PH_CTRL = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } frame_phase_t;
endpackage

// File: rtl/daisy_spi_sync.sv
module daisy_spi_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic csn_in,
  input  logic sclk_in,
  input  logic sdi_in,
  output logic cs_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdi_s
);
  // lane 2 = csn, lane 1 = sclk, lane 0 = sdi
  logic [2:0] pipe [SYNC_STAGES];
  logic       sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= 3'b100;
      sclk_prev <= 1'b0;
    end else begin
      pipe[0] <= {csn_in, sclk_in, sdi_in};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      sclk_prev <= pipe[SYNC_STAGES-1][1];
    end
  end

  assign cs_act    = ~pipe[SYNC_STAGES-1][2];
  assign sclk_rise =  pipe[SYNC_STAGES-1][1] & ~sclk_prev;
  assign sclk_fall = ~pipe[SYNC_STAGES-1][1] &  sclk_prev;
  assign sdi_s     =  pipe[SYNC_STAGES-1][0];
endmodule

// File: rtl/daisy_spi_frame.sv
module daisy_spi_frame
  import daisy_spi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 8,
  parameter int RAM_W  = 16,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi,
  output logic              thru,
  output logic              rd_req,
  output logic              wr_req,
  output logic              space_ram,
  output logic [ADDR_W-1:0] addr,
  output logic [RAM_W-1:0]  wdata,
  output logic              in_data,
  output logic              rd_sel
);
  localparam int CTRL_W   = N_FLAGS + ID_W;
  localparam int MAXLEN   = (RAM_W > CTRL_W) ? ((RAM_W > ADDR_W) ? RAM_W : ADDR_W)
                                             : ((CTRL_W > ADDR_W) ? CTRL_W : ADDR_W);
  localparam int CNT_W    = $clog2(MAXLEN + 1);
  localparam int ID_START = CTRL_W - ID_W;
  localparam logic [RAM_W-1:0] REG_MASK = RAM_W'((64'd1 << REG_W) - 64'd1);

  frame_phase_t     phase;
  logic [CNT_W-1:0] cnt;
  logic [RAM_W-1:0] sh;
  logic [RAM_W-1:0] word;
  logic             borrow;
  logic             thru_nxt;
  logic             hit;
  logic             dir_rd;
  logic [CNT_W-1:0] data_last;

  assign word      = {sh[RAM_W-2:0], sdi};
  assign data_last = space_ram ? CNT_W'(RAM_W - 1) : CNT_W'(REG_W - 1);
  assign in_data   = (phase == PH_DATA);
  assign rd_sel    = hit & dir_rd;

  always_ff @(posedge clk) begin
    rd_req <= 1'b0;
    wr_req <= 1'b0;
    if (rst || !cs_act) begin
      phase     <= PH_CTRL;
      cnt       <= '0;
      sh        <= '0;
      borrow    <= 1'b1;
      thru_nxt  <= 1'b0;
      thru      <= 1'b0;
      hit       <= 1'b0;
      dir_rd    <= 1'b0;
      if (rst) begin
        space_ram <= 1'b0;
        addr      <= '0;
        wdata     <= '0;
      end
    end else begin
      if (rise) begin
        sh  <= word;
        cnt <= cnt + 1'b1;
        // serial decrement: channel number arrives LSB first
        if (phase == PH_CTRL && cnt >= CNT_W'(ID_START)) begin
          thru_nxt <= sdi ^ borrow;
          borrow   <= borrow & ~sdi;
        end else begin
          thru_nxt <= sdi;
        end
        case (phase)
          PH_CTRL: if (cnt == CNT_W'(CTRL_W - 1)) begin
            phase     <= PH_ADDR;
            cnt       <= '0;
            dir_rd    <= word[CTRL_W-1-OFS_RDIR];
            space_ram <= word[CTRL_W-1-OFS_SPACE];
            hit       <= (word[ID_W-1:0] == '0) ||
                         (word[CTRL_W-1-OFS_BCAST] && !word[CTRL_W-1-OFS_RDIR]);
          end
          PH_ADDR: if (cnt == CNT_W'(ADDR_W - 1)) begin
            phase  <= PH_DATA;
            cnt    <= '0;
            addr   <= word[ADDR_W-1:0];
            rd_req <= hit & dir_rd;
          end
          PH_DATA: if (cnt == data_last) begin
            phase <= PH_DONE;
            cnt   <= '0;
            if (hit && !dir_rd) begin
              wr_req <= 1'b1;
              wdata  <= space_ram ? word : (word & REG_MASK);
            end
          end
          default: cnt <= cnt;
        endcase
      end
      if (fall) thru <= thru_nxt;
    end
  end
endmodule

// File: rtl/daisy_spi_readout.sv
module daisy_spi_readout #(
  parameter int REG_W = 8,
  parameter int RAM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_act,
  input  logic             fall,
  input  logic             rd_req,
  input  logic             space_ram,
  input  logic             in_data,
  input  logic             rd_sel,
  input  logic [RAM_W-1:0] rf_rdata,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int ALIGN = RAM_W - REG_W;

  logic [RAM_W-1:0] mem_hold;
  logic [RAM_W-1:0] shreg;
  logic             pend_mem;
  logic             pend_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_hold <= '0;
      shreg    <= '0;
      pend_mem <= 1'b0;
      pend_reg <= 1'b0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      pend_mem <= rd_req &  space_ram;
      pend_reg <= rd_req & ~space_ram;
      // one-deep pipeline: ship the held word, refill from this fetch
      if (rd_req && space_ram) shreg <= mem_hold;
      if (pend_mem) mem_hold <= rf_rdata;
      if (pend_reg) shreg <= rf_rdata << ALIGN;
      if (!cs_act) begin
        sdo    <= 1'b0;
        sdo_oe <= 1'b0;
      end else if (fall && in_data && rd_sel) begin
        sdo    <= shreg[RAM_W-1];
        shreg  <= {shreg[RAM_W-2:0], 1'b0};
        sdo_oe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/daisy_spi_decoder.sv
module daisy_spi_decoder #(
  parameter int ADDR_W      = 8,
  parameter int REG_W       = 8,
  parameter int RAM_W       = 16,
  parameter int ID_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_csn,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic              spi_thru,
  output logic              rf_rd,
  output logic              rf_wr,
  output logic              rf_ram,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [RAM_W-1:0]  rf_wdata,
  input  logic [RAM_W-1:0]  rf_rdata
);
  logic cs_act;
  logic sclk_rise;
  logic sclk_fall;
  logic sdi_s;
  logic in_data;
  logic rd_sel;

  daisy_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .csn_in    (spi_csn),
    .sclk_in   (spi_sclk),
    .sdi_in    (spi_sdi),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdi_s     (sdi_s)
  );

  daisy_spi_frame #(.ADDR_W(ADDR_W), .REG_W(REG_W), .RAM_W(RAM_W), .ID_W(ID_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .rise      (sclk_rise),
    .fall      (sclk_fall),
    .sdi       (sdi_s),
    .thru      (spi_thru),
    .rd_req    (rf_rd),
    .wr_req    (rf_wr),
    .space_ram (rf_ram),
    .addr      (rf_addr),
    .wdata     (rf_wdata),
    .in_data   (in_data),
    .rd_sel    (rd_sel)
  );

  daisy_spi_readout #(.REG_W(REG_W), .RAM_W(RAM_W)) u_readout (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .fall      (sclk_fall),
    .rd_req    (rf_rd),
    .space_ram (rf_ram),
    .in_data   (in_data),
    .rd_sel    (rd_sel),
    .rf_rdata  (rf_rdata),
    .sdo       (spi_sdo),
    .sdo_oe    (spi_sdo_oe)
  );
endmodule

// File: rtl/daisy_spi_decoder_sva.sv
module daisy_spi_decoder_sva (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic sclk_fall,
  input logic spi_sdo,
  input logic spi_sdo_oe,
  input logic spi_thru,
  input logic rf_rd,
  input logic rf_wr
);
  p_oe_off_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_sdo_oe);
  p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !sclk_fall) |=> $stable(spi_sdo));
  p_thru_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_thru);
  p_wr_single_r7: assert property (@(posedge clk) disable iff (rst)
    rf_wr |=> !rf_wr);
  p_rd_single_r6: assert property (@(posedge clk) disable iff (rst)
    rf_rd |=> !rf_rd);
  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rf_rd && rf_wr));
  p_wr_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
    rf_wr |-> $past(cs_act));
endmodule

bind daisy_spi_decoder daisy_spi_decoder_sva u_sva (
  .clk        (clk),
  .rst        (rst),
  .cs_act     (cs_act),
  .sclk_fall  (sclk_fall),
  .spi_sdo    (spi_sdo),
  .spi_sdo_oe (spi_sdo_oe),
  .spi_thru   (spi_thru),
  .rf_rd      (rf_rd),
  .rf_wr      (rf_wr)
);

// File: tb/daisy_spi_decoder_bench.sv
module daisy_spi_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        sdo, sdo_oe, thru, rf_rd, rf_wr, rf_ram;
  logic [7:0]  rf_addr;
  logic [15:0] rf_wdata;
  logic [15:0] rf_rdata = 16'h0;

  logic [7:0]  regs [256];
  logic [15:0] mem  [256];
  int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  daisy_spi_decoder u_daisy_spi_decoder (
    .clk(clk), .rst(rst), .spi_csn(csn), .spi_sclk(sclk), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .spi_thru(thru),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_ram(rf_ram), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // register-file model, one clock read latency
  always @(posedge clk) begin
    if (rf_rd) begin
      rf_rdata <= rf_ram ? mem[rf_addr] : {8'h00, regs[rf_addr]};
      rd_cnt   <= rd_cnt + 1;
    end
    if (rf_wr) begin
      if (rf_ram) mem[rf_addr] <= rf_wdata;
      else        regs[rf_addr] <= rf_wdata[7:0];
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mkctrl(input logic bc, input logic rd, input logic ram,
                                        input logic rsv, input logic [3:0] id);
    return {bc, rd, ram, rsv, id[0], id[1], id[2], id[3]};
  endfunction

  logic [31:0] rx;
  logic [7:0]  thr;
  logic        oe16;

  task automatic xfer(input logic [31:0] tx, input int nbits);
    rx = '0; thr = '0; oe16 = 1'b0;
    csn = 1'b0;
    tick(6);
    for (int k = 0; k < nbits; k++) begin
      sdi = tx[31-k];
      tick(6);
      rx[31-k] = sdo;
      if (k >= 1 && k <= 8) thr[8-k] = thru;
      if (k == 16) oe16 = sdo_oe;
      sclk = 1'b1;
      tick(6);
      sclk = 1'b0;
    end
    tick(6);
    csn = 1'b1;
    tick(8);
  endtask

  task automatic reg_write(input logic bc, input logic [3:0] id, input logic [7:0] a, input logic [7:0] d);
    xfer({mkctrl(bc, 1'b0, 1'b0, 1'b0, id), a, d, 8'h00}, 24);
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
    xfer({mkctrl(1'b0, 1'b1, 1'b0, 1'b1, 4'd0), a, 16'h0000}, 24);
    d = rx[15:8];
  endtask

  task automatic mem_read(input logic [7:0] a, output logic [15:0] d);
    xfer({mkctrl(1'b0, 1'b1, 1'b1, 1'b0, 4'd0), a, 16'h0000}, 32);
    d = rx[15:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rd8;
    logic [15:0] rd16;
    int w0, r0;
    for (int i = 0; i < 256; i++) begin
      regs[i] = 8'(i) ^ 8'h5A;
      mem[i]  = (16'(i) * 16'h0101) ^ 16'h3C00;
    end
    tick(4);
    rst = 1'b0;
    tick(2);
    // R10 reset state
    check("R10 oe",   {31'b0, sdo_oe}, 0);
    check("R10 sdo",  {31'b0, sdo},    0);
    check("R10 thru", {31'b0, thru},   0);
    check("R10 strobes", {30'b0, rf_rd, rf_wr}, 0);

    // R2 / R4 / R1: unicast write sweep over all channel numbers
    for (int id = 0; id < 16; id++) begin
      logic [7:0] c;
      c  = mkctrl(1'b0, 1'b0, 1'b0, 1'b0, 4'(id));
      w0 = wr_cnt;
      reg_write(1'b0, 4'(id), 8'h20 + 8'(id), 8'hA0 + 8'(id));
      check("R2 unicast write only at zero", wr_cnt - w0, (id == 0) ? 1 : 0);
      check("R4 R1 forwarded control", {24'b0, thr},
            {24'b0, mkctrl(1'b0, 1'b0, 1'b0, 1'b0, 4'(id - 1))});
      if (c[7:4] != 4'b0000) check("R1 flags", 0, 1);
    end
    reg_read(8'h20, rd8);
    check("R7 R5 register written", {24'b0, rd8}, 32'hA0);
    reg_read(8'h21, rd8);
    check("R2 register untouched", {24'b0, rd8}, {24'b0, 8'h21 ^ 8'h5A});

    // R3 broadcast write sweep, R8 no output enable on writes
    for (int id = 0; id < 16; id++) begin
      w0 = wr_cnt;
      xfer({mkctrl(1'b1, 1'b0, 1'b0, 1'b1, 4'(id)), 8'h40 + 8'(id), 8'hC0 + 8'(id), 8'h00}, 24);
      check("R3 broadcast write", wr_cnt - w0, 1);
      check("R8 no oe on write", {31'b0, oe16}, 0);
      check("R4 broadcast forwarded", {24'b0, thr},
            {24'b0, mkctrl(1'b1, 1'b0, 1'b0, 1'b1, 4'(id - 1))});
    end
    reg_read(8'h4F, rd8);
    check("R3 broadcast data", {24'b0, rd8}, 32'hCF);

    // R3 broadcast reads with nonzero number are ignored
    for (int id = 1; id < 16; id++) begin
      r0 = rd_cnt;
      xfer({mkctrl(1'b1, 1'b1, 1'b0, 1'b0, 4'(id)), 8'h05, 16'h0000}, 24);
      check("R3 broadcast read no strobe", rd_cnt - r0, 0);
      check("R8 broadcast read no oe", {31'b0, oe16}, 0);
    end

    // R5 / R8 register reads at several addresses
    for (int a = 0; a < 256; a += 37) begin
      xfer({mkctrl(1'b1, 1'b1, 1'b0, 1'b0, 4'd0), 8'(a), 16'h0000}, 24);
      check("R5 register read", {24'b0, rx[15:8]}, {24'b0, regs[a]});
      check("R8 oe on addressed read", {31'b0, oe16}, 1);
    end

    // R6 memory read pipeline
    mem_read(8'h11, rd16);
    check("R6 first memory read after reset", {16'b0, rd16}, 0);
    mem_read(8'h22, rd16);
    check("R6 previous word", {16'b0, rd16}, {16'b0, mem[8'h11]});
    w0 = wr_cnt;
    xfer({mkctrl(1'b0, 1'b0, 1'b1, 1'b0, 4'd0), 8'h33, 16'hBEEF}, 32);
    check("R7 memory write strobe", wr_cnt - w0, 1);
    mem_read(8'h33, rd16);
    check("R6 write does not disturb pipe", {16'b0, rd16}, {16'b0, mem[8'h22]});
    // R9 aborted memory read inside address byte
    r0 = rd_cnt;
    xfer({mkctrl(1'b0, 1'b1, 1'b1, 1'b0, 4'd0), 8'h44, 16'h0000}, 12);
    check("R9 aborted read no strobe", rd_cnt - r0, 0);
    mem_read(8'h55, rd16);
    check("R9 R7 pipe after abort", {16'b0, rd16}, 32'h0000BEEF);

    // R9 aborted register and memory writes
    w0 = wr_cnt;
    xfer({mkctrl(1'b0, 1'b0, 1'b0, 1'b0, 4'd0), 8'h60, 8'h99, 8'h00}, 20);
    xfer({mkctrl(1'b0, 1'b0, 1'b1, 1'b0, 4'd0), 8'h61, 16'h1234}, 31);
    check("R9 aborted writes", wr_cnt - w0, 0);
    reg_read(8'h60, rd8);
    check("R9 register unchanged", {24'b0, rd8}, {24'b0, 8'h60 ^ 8'h5A});
    check("R8 oe off after frame", {31'b0, sdo_oe}, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule